// File: doc/BRIEF.md
# Interrupt Control and Status Register

This block keeps the interrupt state of a small packet interface in one word that software can read and write. Three flags live in it. A transmit-complete flag and a receive-complete flag are raised by one-cycle pulses from the packet paths. A software test flag is raised by a register write and dropped by a register read. While any flag is set, the single interrupt line stays high.

Software acknowledges flags by writing the register. Each write acts on at most one flag, chosen by fixed priority: transmit-complete first, then receive-complete, then the test flag is raised. A busy bit is refreshed only on write cycles. It shows whether any flag is still set once that write has taken effect. Reads return the word as it was before the read cleared the test flag, so software sees a test interrupt exactly once.

Top module: `intr_status_reg`

## Requirements
- R1: After synchronous active-high reset, all flags are clear and `rd_data`, `irq` and `busy` are 0.
- R2: A pulse on `tx_event` sets the transmit flag (word bit 0). A pulse on `rx_event` sets the receive flag (word bit 1). Both become visible on the clock edge that samples the pulse.
- R3: A write with bit 0 set clears only the transmit flag. The receive and test flags are unchanged even when bits 1 or 31 are also set.
- R4: A write with bit 0 clear and bit 1 set clears only the receive flag.
- R5: A write with bits 0 and 1 clear and bit 31 set raises the test flag (word bit 31). A write that also carries bit 0 or bit 1 leaves the test flag as it was.
- R6: `rd_en` loads `rd_data` on the next edge with the flag word as it was before that edge, and clears the test flag. `rd_data` holds its value between reads.
- R7: `irq` is 1 exactly when at least one flag is set, and it follows the flags on the same edge.
- R8: On a write cycle, `busy` is loaded with whether any flag remains set after that cycle. On cycles without a write, `busy` keeps its value, even while events change the flags.
- R9: If an event pulse and a write that clears the same flag arrive in one cycle, the flag ends up set.
- R10: If a read and a test-raising write arrive in one cycle, the test flag ends up set.
- R11: Write data bits other than 0, 1 and 31 have no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wr_data | input | 32 | Write data (acknowledge / test bits) |
| tx_event | input | 1 | Transmit-complete pulse |
| rx_event | input | 1 | Receive-complete pulse |
| rd_data | output | 32 | Flag word captured by the last read |
| irq | output | 1 | Level interrupt, any flag set |
| busy | output | 1 | Any-flag status, refreshed on writes |

## Verification
The hardest situations to reach are the collisions: an event arriving in the same cycle as the write that would clear its flag, and a read landing in the same cycle as a test-raising write. A third hard case is the stale busy bit, where `irq` has moved because of an event while `busy` still shows the result of the last write. Directed cycles set up each of these collisions on purpose. After that, an exhaustive sweep drives every combination of the two strobes, both events and a write pattern built from bits 0, 1, 31 and a reserved bit. The sweep runs three times, so each combination meets several different prior flag states, and every output is compared with a model that the bench computes from the priority rules.

// File: rtl/icsr_pkg.sv
package icsr_pkg;
  // number of event-driven flags (transmit, receive)
  localparam int unsigned N_EVT = 2;
  localparam int unsigned EV_TX = 0;
  localparam int unsigned EV_RX = 1;
  // full flag vector: event flags then test flag on top
  localparam int unsigned N_FLAG = N_EVT + 1;
  typedef logic [N_FLAG-1:0] flag_vec_t;
endpackage

// File: rtl/icsr_ack_decode.sv
module icsr_ack_decode #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned TX_POS   = 0,
  parameter int unsigned RX_POS   = 1,
  parameter int unsigned TEST_POS = 31
) (
  input  logic                           wr_en,
  input  logic [DATA_W-1:0]              wr_data,
  output logic [icsr_pkg::N_EVT-1:0]     ack,
  output logic                           set_test
);
  import icsr_pkg::*;

  logic unused_bits;
  assign unused_bits = ^wr_data;

  // fixed priority: transmit ack, then receive ack, then test raise
  always_comb begin
    ack      = '0;
    set_test = 1'b0;
    if (wr_en) begin
      if (wr_data[TX_POS])        ack[EV_TX] = 1'b1;
      else if (wr_data[RX_POS])   ack[EV_RX] = 1'b1;
      else if (wr_data[TEST_POS]) set_test   = 1'b1;
    end
  end
endmodule

// File: rtl/icsr_flag_bank.sv
module icsr_flag_bank (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [icsr_pkg::N_EVT-1:0] evt,
  input  logic [icsr_pkg::N_EVT-1:0] ack,
  input  logic                       set_test,
  input  logic                       rd_en,
  output icsr_pkg::flag_vec_t        flags_q,
  output icsr_pkg::flag_vec_t        flags_d
);
  import icsr_pkg::*;

  localparam int unsigned TEST_IDX = N_FLAG - 1;

  genvar gi;
  generate
    for (gi = 0; gi < N_EVT; gi++) begin : g_evt
      // event beats a same-cycle acknowledge
      assign flags_d[gi] = evt[gi] | (flags_q[gi] & ~ack[gi]);

      always_ff @(posedge clk) begin
        if (rst) flags_q[gi] <= 1'b0;
        else     flags_q[gi] <= flags_d[gi];
      end

      // R2 / R9: a pulse always leaves its flag set
      p_evt_sets_r9: assert property (@(posedge clk) disable iff (rst)
        evt[gi] |=> flags_q[gi]);
      // R3 / R4: an acknowledge without a competing event clears the flag
      p_ack_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (ack[gi] && !evt[gi]) |=> !flags_q[gi]);
    end
  endgenerate

  // test flag: raised by write, dropped by read, raise wins
  assign flags_d[TEST_IDX] = set_test | (flags_q[TEST_IDX] & ~rd_en);

  always_ff @(posedge clk) begin
    if (rst) flags_q[TEST_IDX] <= 1'b0;
    else     flags_q[TEST_IDX] <= flags_d[TEST_IDX];
  end

  // R6: a read without a raise drops the test flag
  p_read_drops_test_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !set_test) |=> !flags_q[TEST_IDX]);
  // R5 / R10: a raise always lands
  p_raise_test_r10: assert property (@(posedge clk) disable iff (rst)
    set_test |=> flags_q[TEST_IDX]);
endmodule

// File: rtl/intr_status_reg.sv
module intr_status_reg #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned TX_POS   = 0,
  parameter int unsigned RX_POS   = 1,
  parameter int unsigned TEST_POS = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tx_event,
  input  logic              rx_event,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq,
  output logic              busy
);
  import icsr_pkg::*;

  localparam int unsigned TEST_IDX = N_FLAG - 1;

  logic [N_EVT-1:0] evt;
  logic [N_EVT-1:0] ack;
  logic             set_test;
  flag_vec_t        flags_q;
  flag_vec_t        flags_d;
  logic [DATA_W-1:0] word_q;

  assign evt[EV_TX] = tx_event;
  assign evt[EV_RX] = rx_event;

  icsr_ack_decode #(
    .DATA_W(DATA_W), .TX_POS(TX_POS), .RX_POS(RX_POS), .TEST_POS(TEST_POS)
  ) u_dec (
    .wr_en(wr_en), .wr_data(wr_data), .ack(ack), .set_test(set_test)
  );

  icsr_flag_bank u_bank (
    .clk(clk), .rst(rst), .evt(evt), .ack(ack), .set_test(set_test),
    .rd_en(rd_en), .flags_q(flags_q), .flags_d(flags_d)
  );

  // place flags at their word positions
  always_comb begin
    word_q           = '0;
    word_q[TX_POS]   = flags_q[EV_TX];
    word_q[RX_POS]   = flags_q[EV_RX];
    word_q[TEST_POS] = flags_q[TEST_IDX];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq     <= 1'b0;
      busy    <= 1'b0;
    end else begin
      irq <= |flags_d;
      if (rd_en) rd_data <= word_q;
      if (wr_en) busy    <= |flags_d;
    end
  end

  // R8: busy moves only on write cycles
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(busy));
  // R8 / R7: right after a write, busy and irq agree
  p_busy_match_r8: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (busy == irq));
  // R7: irq can only rise from an event or a write
  p_irq_rise_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(tx_event || rx_event || wr_en));
  // R6: rd_data holds between reads
  p_rd_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/tb_intr_status_reg.sv
module tb_intr_status_reg;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0, tx_event = 1'b0, rx_event = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq, busy;

  int checks = 0;
  int fails  = 0;

  // bench model state
  logic        m_tx = 0, m_rx = 0, m_test = 0, m_busy = 0;
  logic [31:0] m_rd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_status_reg dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data),
    .tx_event(tx_event), .rx_event(rx_event), .rd_data(rd_data),
    .irq(irq), .busy(busy)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_word();
    logic [31:0] w = '0;
    w[0] = m_tx; w[1] = m_rx; w[31] = m_test;
    return w;
  endfunction

  // one bus cycle: drive, step the model, compare all outputs
  task automatic cyc(input logic w, input logic r, input logic t,
                     input logic x, input logic [31:0] d, input string req);
    logic ack_t, ack_r, raise;
    wr_en = w; rd_en = r; tx_event = t; rx_event = x; wr_data = d;
    ack_t = w & d[0];
    ack_r = w & ~d[0] & d[1];
    raise = w & ~d[0] & ~d[1] & d[31];
    if (r) m_rd = m_word();
    m_tx   = t | (m_tx & ~ack_t);
    m_rx   = x | (m_rx & ~ack_r);
    m_test = raise | (m_test & ~r);
    if (w) m_busy = m_tx | m_rx | m_test;
    @(posedge clk); #1;
    wr_en = 0; rd_en = 0; tx_event = 0; rx_event = 0; wr_data = '0;
    chk(req, "rd_data", rd_data, m_rd);
    chk(req, "irq", {31'b0, irq}, {31'b0, m_tx | m_rx | m_test});
    chk(req, "busy", {31'b0, busy}, {31'b0, m_busy});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 rst = 0;
    // R1: reset state
    chk("R1", "rd_data", rd_data, 32'h0);
    chk("R1", "irq", {31'b0, irq}, 32'h0);
    chk("R1", "busy", {31'b0, busy}, 32'h0);

    cyc(0, 0, 1, 0, 32'h0, "R2");           // tx flag, busy stays 0 (R8)
    cyc(0, 1, 0, 0, 32'h0, "R6");           // read sees bit 0
    cyc(0, 0, 0, 1, 32'h0, "R2");           // rx flag
    cyc(0, 1, 0, 0, 32'h0, "R2");           // read sees bits 0,1
    cyc(1, 0, 0, 0, 32'h8000_0003, "R3");   // only tx cleared
    cyc(0, 1, 0, 0, 32'h0, "R3");
    cyc(1, 0, 0, 0, 32'h8000_0002, "R4");   // only rx cleared, no raise
    cyc(0, 1, 0, 0, 32'h0, "R4");
    cyc(1, 0, 0, 0, 32'h8000_0000, "R5");   // raise test
    cyc(1, 0, 0, 0, 32'h8000_0001, "R5");   // raise blocked by bit 0
    cyc(0, 1, 0, 0, 32'h0, "R6");           // sees test, then clears
    cyc(0, 1, 0, 0, 32'h0, "R6");           // test gone
    cyc(0, 0, 1, 1, 32'h0, "R8");           // irq up, busy stale
    cyc(1, 0, 0, 0, 32'h7FFF_FFFC, "R11");  // reserved bits only
    cyc(0, 1, 0, 0, 32'h0, "R11");
    cyc(1, 0, 1, 0, 32'h0000_0001, "R9");   // event beats ack
    cyc(1, 0, 0, 1, 32'h0000_0002, "R9");
    cyc(0, 1, 0, 0, 32'h0, "R9");
    cyc(1, 1, 0, 0, 32'h8000_0000, "R10");  // raise beats read
    cyc(0, 1, 0, 0, 32'h0, "R10");
    cyc(0, 0, 0, 0, 32'h0, "R7");

    // exhaustive sweep, three passes for varied prior state
    for (int pass = 0; pass < 3; pass++) begin
      for (int c = 0; c < 256; c++) begin
        int k;
        logic [31:0] d;
        k = (pass == 1) ? (255 - c) : ((c * 37 + pass) % 256);
        d = '0;
        d[0] = k[4]; d[1] = k[5]; d[31] = k[6]; d[5] = k[7];
        cyc(k[0], k[1], k[2], k[3], d, "R7_R8_sweep");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule